// File: doc/BRIEF.md
# Segmented Base-Limit Address Translator

This block maps a 16-bit virtual address to an 18-bit physical address. It uses a small set of per-segment base and bound registers. A two-bit configuration input sets how many of the top address bits pick a segment. The remaining low bits form the offset inside that segment.

The offset is compared with the selected segment's bound. If the offset is inside the bound, the physical address is the offset plus the segment's base. If the offset is not inside the bound, the block flags an address exception and drives no address.

When the configuration picks no segment bits, the whole address is the offset. The block then behaves as a single-region relocator using segment 0's registers. A write port lets controlling software install a fresh base and bound into any segment, for example at each process switch. Translation is combinational, and a result stage registers its output. Each request therefore gets exactly one response, one clock later.

Top module: `segxl_translator`

## Requirements
- R1: A request presented with `req_valid` high at a rising edge produces `rsp_valid` high during the following cycle.
- R2: With `cfg_seg_bits` = 0, all 16 bits of `req_vaddr` are the offset, and segment 0's base and bound are used.
- R3: With `cfg_seg_bits` = 1, bit 15 selects segment 0 or 1, and bits 14..0 are the offset.
- R4: With `cfg_seg_bits` = 2, bits 15..14 select segments 0 to 3, and bits 13..0 are the offset. The value 3 behaves exactly like 2.
- R5: When the offset is greater than or equal to the selected bound, `rsp_fault` is 1 and `rsp_paddr` is 0.
- R6: When the offset is below the selected bound, `rsp_fault` is 0 and `rsp_paddr` equals (base + offset) modulo 2^18.
- R7: A rising edge with `wr_en` high loads `wr_base` and `wr_limit` into the segment numbered `wr_sel`.
- R8: A register write and a request in the same cycle: the request is translated with the register values from before the write. The written values apply from the next request on.
- R9: Reset clears every base and bound to zero, so every access faults until software programs the registers. Reset also drops `rsp_valid` to 0.
- R10: In a cycle after an edge with `req_valid` low, `rsp_valid`, `rsp_fault` and `rsp_paddr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_seg_bits | input | 2 | Number of segment-select bits (0, 1, 2; 3 acts as 2) |
| wr_en | input | 1 | Load one segment's registers |
| wr_sel | input | 2 | Segment to load |
| wr_base | input | 18 | New base (relocation) value |
| wr_limit | input | 17 | New bound in bytes (up to 65536) |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 16 | Virtual address to translate |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_fault | output | 1 | Offset outside the bound |
| rsp_paddr | output | 18 | Physical address, 0 when faulting or idle |

## Verification
A register write and a translation can fall on the same clock edge. The conflict matters when both target the same segment. The bench provokes this case by asserting `wr_en` and `req_valid` together on one segment. It installs a base and bound that would change both the address and the fault result. It judges the response against the old values. It then repeats the request on the next cycles to confirm the new values are in force, both past and inside the new bound.

// File: rtl/segxl_pkg.sv
package segxl_pkg;
    parameter int VA_W         = 16;
    parameter int PA_W         = 18;
    parameter int SEG_BITS_MAX = 2;

    localparam int NSEG  = 1 << SEG_BITS_MAX;
    localparam int SEL_W = SEG_BITS_MAX;
    localparam int LIM_W = VA_W + 1;

    typedef logic [VA_W-1:0]  vaddr_t;
    typedef logic [PA_W-1:0]  paddr_t;
    typedef logic [LIM_W-1:0] limit_t;
    typedef logic [SEL_W-1:0] sel_t;

    typedef enum logic [1:0] {
        MODE_FLAT    = 2'd0,
        MODE_HALVES  = 2'd1,
        MODE_QUADS   = 2'd2,
        MODE_QUADS_B = 2'd3
    } seg_mode_e;

    typedef struct packed {
        paddr_t base;
        limit_t limit;
    } seg_entry_t;

    typedef struct packed {
        sel_t   sel;
        vaddr_t offset;
    } split_t;

    typedef struct packed {
        logic   valid;
        logic   fault;
        paddr_t paddr;
    } xlate_rsp_t;

    // Number of select bits actually used, clamped to the table size.
    function automatic int seg_bits(seg_mode_e m);
        int k;
        k = int'(m);
        if (k > SEG_BITS_MAX) k = SEG_BITS_MAX;
        return k;
    endfunction

    function automatic split_t split_addr(seg_mode_e m, vaddr_t va);
        split_t r;
        int k;
        k = seg_bits(m);
        if (k == 0) begin
            r.sel    = '0;
            r.offset = va;
        end else begin
            r.sel    = sel_t'(va >> (VA_W - k));
            r.offset = va & (vaddr_t'({VA_W{1'b1}}) >> k);
        end
        return r;
    endfunction
endpackage

// File: rtl/segxl_regfile.sv
module segxl_regfile
    import segxl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  sel_t       wr_sel,
    input  seg_entry_t wr_entry,
    input  sel_t       rd_sel,
    output seg_entry_t rd_entry
);
    seg_entry_t entries [NSEG];

    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst)
                entries[i] <= '0;
            else if (wr_en && wr_sel == sel_t'(i))
                entries[i] <= wr_entry;
        end

        // R7: a write to this segment is visible after the edge
        p_write_lands_r7: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_sel == sel_t'(i)) |=> entries[i] == $past(wr_entry));

        // R7: other segments hold their value across a write elsewhere
        p_write_isolated_r7: assert property (@(posedge clk) disable iff (rst)
            (!(wr_en && wr_sel == sel_t'(i))) |=> $stable(entries[i]));
    end

    assign rd_entry = entries[rd_sel];
endmodule

// File: rtl/segxl_bound.sv
module segxl_bound
    import segxl_pkg::*;
(
    input  split_t     addr,
    input  seg_entry_t seg,
    output logic       fault,
    output paddr_t     paddr
);
    always_comb begin
        fault = limit_t'(addr.offset) >= seg.limit;
        paddr = fault ? '0 : paddr_t'(seg.base + paddr_t'(addr.offset));
    end
endmodule

// File: rtl/segxl_translator.sv
module segxl_translator
    import segxl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            cfg_seg_bits,
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      wr_sel,
    input  logic [PA_W-1:0]       wr_base,
    input  logic [LIM_W-1:0]      wr_limit,
    input  logic                  req_valid,
    input  logic [VA_W-1:0]       req_vaddr,
    output logic                  rsp_valid,
    output logic                  rsp_fault,
    output logic [PA_W-1:0]       rsp_paddr
);
    split_t     split_w;
    seg_entry_t seg_w;
    seg_entry_t wr_entry_w;
    logic       fault_w;
    paddr_t     paddr_w;
    xlate_rsp_t rsp_q;

    assign split_w    = split_addr(seg_mode_e'(cfg_seg_bits), req_vaddr);
    assign wr_entry_w = '{base: wr_base, limit: wr_limit};

    segxl_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_entry (wr_entry_w),
        .rd_sel   (split_w.sel),
        .rd_entry (seg_w)
    );

    segxl_bound u_bound (
        .addr  (split_w),
        .seg   (seg_w),
        .fault (fault_w),
        .paddr (paddr_w)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rsp_q <= '0;
        else if (req_valid)
            rsp_q <= '{valid: 1'b1, fault: fault_w, paddr: paddr_w};
        else
            rsp_q <= '0;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_fault = rsp_q.fault;
    assign rsp_paddr = rsp_q.paddr;

    // R1: every request is answered on the next cycle
    p_resp_timing_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R10: no request, quiet outputs
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_fault && rsp_paddr == '0));

    // R5: a fault carries no address and only appears on a response
    p_fault_no_addr_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_valid && rsp_paddr == '0));

    // R9: the cycle after reset is released carries no response
    p_reset_quiet_r9: assert property (@(posedge clk)
        $past(rst) |-> !rsp_valid);
endmodule

// File: tb/test_segxl_translator.sv
module test_segxl_translator;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_seg_bits = 2'd0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [17:0] wr_base = '0;
    logic [16:0] wr_limit = '0;
    logic        req_valid = 1'b0;
    logic [15:0] req_vaddr = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [17:0] rsp_paddr;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 0;

    logic [17:0] mb [4];
    logic [16:0] ml [4];

    always #2.5 clk = ~clk;

    segxl_translator i_segxl_translator (
        .clk(clk), .rst(rst), .cfg_seg_bits(cfg_seg_bits),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_base(wr_base), .wr_limit(wr_limit),
        .req_valid(req_valid), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual cycles %0d expected < 190000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(int s, logic [17:0] b, logic [16:0] l);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(s); wr_base = b; wr_limit = l;
        @(negedge clk);
        wr_en = 1'b0;
        mb[s] = b; ml[s] = l;
    endtask

    function automatic void model(logic [15:0] va, output logic f, output logic [17:0] pa);
        int k;
        int s;
        logic [15:0] off;
        k = (cfg_seg_bits > 2) ? 2 : int'(cfg_seg_bits);
        s = (k == 0) ? 0 : int'(va >> (16 - k));
        off = va & (16'hFFFF >> k);
        f = ({1'b0, off} >= ml[s]);
        pa = f ? 18'h0 : 18'((mb[s] + {2'b00, off}) & 18'h3FFFF);
    endfunction

    task automatic xlate(logic [15:0] va, string tag);
        logic ef;
        logic [17:0] ep;
        model(va, ef, ep);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R1", {tag, " valid"}, 32'(rsp_valid), 32'd1);
        chk(rsp_fault == ef, "R5", {tag, " fault"}, 32'(rsp_fault), 32'(ef));
        chk(rsp_paddr == ep, "R6", {tag, " paddr"}, 32'(rsp_paddr), 32'(ep));
    endtask

    // Sweep with a stride, then hit both sides of each used segment's bound.
    task automatic sweep(int step, string tag);
        int k;
        k = (cfg_seg_bits > 2) ? 2 : int'(cfg_seg_bits);
        for (int v = 0; v < 65536; v += step) xlate(16'(v), tag);
        for (int s = 0; s < (1 << k); s++) begin
            int start;
            int span;
            start = s << (16 - k);
            span  = 1 << (16 - k);
            if (ml[s] > 0 && int'(ml[s]) <= span) xlate(16'(start + int'(ml[s]) - 1), tag);
            if (int'(ml[s]) < span) xlate(16'(start + int'(ml[s])), tag);
            xlate(16'(start + span - 1), tag);
        end
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin mb[i] = '0; ml[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state, and unprogrammed bounds fault everywhere
        chk(rsp_valid == 1'b0, "R9", "valid after reset", 32'(rsp_valid), 32'd0);
        cfg_seg_bits = 2'd0;
        xlate(16'h0000, "R9 flat");
        cfg_seg_bits = 2'd2;
        xlate(16'hC123, "R9 quads");

        // R2: single-region mode
        cfg_seg_bits = 2'd0;
        wr(0, 18'h2A000, 17'h0C000);
        sweep(7, "R2");
        wr(0, 18'h3F000, 17'h10000);   // full range, sum wraps modulo 2^18
        sweep(7, "R2 wrap");

        // R3: two segments
        cfg_seg_bits = 2'd1;
        wr(0, 18'h10000, 17'h05000);
        wr(1, 18'h38000, 17'h08000);
        sweep(7, "R3");

        // R4: four segments, then the alias encoding
        cfg_seg_bits = 2'd2;
        wr(0, 18'h00100, 17'h02000);
        wr(1, 18'h20000, 17'h04000);
        wr(2, 18'h3C000, 17'h03FFF);
        wr(3, 18'h08000, 17'h00001);
        sweep(7, "R4");
        cfg_seg_bits = 2'd3;
        sweep(97, "R4 alias");

        // R8: write and request on the same edge to the same segment
        cfg_seg_bits = 2'd2;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 16'h4010;
        wr_en = 1'b1; wr_sel = 2'd1; wr_base = 18'h11000; wr_limit = 17'h00008;
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        chk(rsp_fault == 1'b0, "R8", "old bound used", 32'(rsp_fault), 32'd0);
        chk(rsp_paddr == 18'h20010, "R8", "old base used", 32'(rsp_paddr), 32'h20010);
        mb[1] = 18'h11000; ml[1] = 17'h00008;
        xlate(16'h4010, "R8 R7 new bound");
        xlate(16'h4007, "R8 R7 new base");

        // R10: idle cycle after a response
        @(negedge clk);
        chk(rsp_valid == 1'b0 && rsp_fault == 1'b0 && rsp_paddr == '0, "R10", "idle outputs",
            {13'd0, rsp_valid, rsp_fault, rsp_paddr[16:0]}, 32'd0);

        // R9: reset mid-run clears the programmed registers
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 4; i++) begin mb[i] = '0; ml[i] = '0; end
        xlate(16'h0001, "R9 after rerun reset");
        xlate(16'h8000, "R9 after rerun reset");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule